// File: doc/BRIEF.md
# Programmable-Flag FIFO with Retransmit

A single-clock first-in first-out buffer of depth `D` words with a registered read port, five active-low status flags and a rewind operation. The read timing is chosen when the master reset is applied. In standard timing a word leaves the buffer one clock after a read request, and the status pair reports "empty" and "full". In fall-through timing the oldest word moves on its own into an output register, where it waits for the consumer. The status pair then reports "output holds a word" and "a write would be taken", and the output register adds one word of capacity (`D+1`).

Besides the two main flags, the block drives a half-full flag and two threshold flags. The almost-empty and almost-full thresholds come from offsets `n` and `m`, which a one-cycle load strobe sets. A master reset returns the timing mode and both offsets to their defaults. A partial reset empties the buffer but keeps them. The retransmit request rewinds reading to the first word written since the last reset, with no idle cycle. This serves a producer that writes a packet of at most `D` words and may need to replay it.

Top module: `pf_fifo`

## Requirements
- R1: While `mrst_n` is low at a clock edge, the buffer is emptied, `rd_data` becomes 0, the timing mode is taken from `fwft_sel` (0 standard, 1 fall-through), and the offsets return to `DEF_N` and `DEF_M`. Afterwards the flags read: standard `ef_or_n`=0, `ff_ir_n`=1; fall-through `ef_or_n`=1, `ff_ir_n`=0; `pae_n`=0, `hf_n`=1 in both modes.
- R2: While `prst_n` is low at a clock edge (with `mrst_n` high), the buffer is emptied and `rd_data` becomes 0. The timing mode and the offsets keep their values, and an offset load in that cycle is ignored.
- R3: In standard mode, an accepted read places the oldest word on `rd_data` at that clock edge, in write order. `ef_or_n` is low exactly when no word is held, and `ff_ir_n` is low exactly when `D` words are held.
- R4: In fall-through mode, a written word reaches `rd_data` one clock after its write edge without any read request. `ef_or_n` is low exactly while `rd_data` holds an unread word, a read consumes that word, and up to `D+1` words are held. `ff_ir_n` is low exactly while a write would be accepted.
- R5: A write while full, or a read with nothing to read, is ignored: the stored words and their order are unchanged, and after an ignored read `rd_data` keeps its value.
- R6: `pae_n` is low exactly while the number of readable words (those held, including the output word in fall-through mode) is `n` or fewer.
- R7: `paf_n` is low exactly while the held words number at least `C-m`, with capacity `C` = `D` (standard) or `D+1` (fall-through). Without reads, it therefore falls after `C-m` writes from empty.
- R8: `hf_n` is low exactly while more than `C/2` words (integer division) are held.
- R9: A pulse on `ofs_ld` loads `ofs_empty` into `n` and `ofs_full` into `m`, and the flags use the new offsets from that same edge.
- R10: An accepted retransmit moves reading back to the first word written since the last reset, with no wait cycle. In standard mode the next read returns that word. In fall-through mode the word is on `rd_data`, with `ef_or_n` low, right after the request edge. A read in the same cycle is ignored, and all words written since the reset are readable again.
- R11: A retransmit request is ignored unless at least 2 writes and at least 2 reads have been accepted since the last reset, and the writes accepted so far, counting the one in the same cycle, number at most `D`.
- R12: Every flag is a register that takes its new value on the same clock edge at which the stored count, the mode or an offset changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| fwft_sel | input | 1 | Timing mode captured at master reset: 0 standard, 1 fall-through |
| ofs_ld | input | 1 | Offset load strobe |
| ofs_empty | input | CW | New almost-empty offset `n` |
| ofs_full | input | CW | New almost-full offset `m` |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read request |
| rt_req | input | 1 | Retransmit request |
| rd_data | output | W | Registered read data |
| ef_or_n | output | 1 | Standard: empty; fall-through: output word ready (active low) |
| ff_ir_n | output | 1 | Standard: full; fall-through: input ready (active low) |
| pae_n | output | 1 | Almost empty (active low) |
| paf_n | output | 1 | Almost full (active low) |
| hf_n | output | 1 | More than half full (active low) |

## Verification
A fault in a pointer or in the word count shows up in the flags on the very edge of the wrong update. It can take longer to show in the data: a skipped or repeated word reaches `rd_data` only when that slot is read. The threshold flags sit at different levels, and the bench moves the fill level across all of them. A corrupt count therefore flips at least one flag within a few cycles, even while the data is still correct. A wrong retransmit bookkeeping value is caught at the first read after the rewind, and in fall-through mode at the request edge itself.

// File: rtl/pf_pkg.sv
// Shared types for the programmable-flag FIFO.
package pf_pkg;
    // Read timing selected at master reset
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/pf_store.sv
// Storage array: one synchronous write port and one combinational read port.
// Assumes the controller never reads a slot in the cycle it is written.
module pf_store #(
    parameter int W  = 8,
    parameter int D  = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [D];

    // Write the accepted word into its slot
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pf_cfg.sv
// Configuration holder: timing mode and flag offsets.
// Master reset loads defaults and samples the mode pin; partial reset keeps
// everything and blocks offset loads. Next-state values are exported so the
// flag register can follow them on the same edge.
module pf_cfg
    import pf_pkg::*;
#(
    parameter int CW    = 5,
    parameter int DEF_N = 2,
    parameter int DEF_M = 3
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          ld,
    input  logic [CW-1:0] ld_n,
    input  logic [CW-1:0] ld_m,
    output rd_mode_e      mode_q,
    output rd_mode_e      mode_d,
    output logic [CW-1:0] n_q,
    output logic [CW-1:0] n_d,
    output logic [CW-1:0] m_q,
    output logic [CW-1:0] m_d
);
    localparam logic [CW-1:0] N_RST = CW'(DEF_N);
    localparam logic [CW-1:0] M_RST = CW'(DEF_M);

    // Next configuration: defaults on master reset, load when running
    always_comb begin
        mode_d = mode_q;
        n_d    = n_q;
        m_d    = m_q;
        if (!mrst_n) begin
            mode_d = mode_sel ? MODE_FWFT : MODE_STD;
            n_d    = N_RST;
            m_d    = M_RST;
        end else if (prst_n && ld) begin
            n_d = ld_n;
            m_d = ld_m;
        end
    end

    // Hold configuration
    always_ff @(posedge clk) begin
        mode_q <= mode_d;
        n_q    <= n_d;
        m_q    <= m_d;
    end
endmodule

// File: rtl/pf_ctrl.sv
// Pointer, count and output-register control for both timing modes.
// Standard mode: an accepted read loads the oldest word into the output
// register. Fall-through mode: the output register refills by itself
// whenever it is empty or being consumed. Retransmit rewinds the read
// pointer to slot 0, which holds the first word since reset as long as no
// more than D words have been written. Both resets are synchronous.
module pf_ctrl
    import pf_pkg::*;
#(
    parameter int W  = 8,
    parameter int D  = 16,
    parameter int AW = 4,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  rd_mode_e      mode,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rt_req,
    input  logic [W-1:0]  mem_rdata,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic          outv_q,
    output logic          outv_d
);
    localparam logic [CW-1:0] DEP    = CW'(D);
    localparam logic [CW-1:0] WT_MAX = CW'(D + 1);
    localparam logic [CW-1:0] TWO    = CW'(2);
    localparam logic [AW-1:0] LAST   = AW'(D - 1);

    logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
    logic [CW-1:0] wtot_q, wtot_d, wsum;
    logic [1:0]    rtot_q, rtot_d;
    logic [W-1:0]  dout_q, dout_d;
    logic          run, fw, wr_acc, rd_acc, pop, load, rt_ok;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    // Request qualification
    always_comb begin
        run    = mrst_n && prst_n;
        fw     = (mode == MODE_FWFT);
        wr_acc = wr_en && (cnt_q < DEP);
        wsum   = wtot_q + {{(CW-1){1'b0}}, wr_acc};
        rt_ok  = rt_req && (wtot_q >= TWO) && (rtot_q == 2'd2) && (wsum <= DEP);
        pop    = fw && rd_en && outv_q;
        load   = fw && (cnt_q != '0) && (!outv_q || pop);
        rd_acc = !fw && rd_en && (cnt_q != '0);
        raddr  = rt_ok ? '0 : rptr_q;
        we     = run && wr_acc;
        waddr  = wptr_q;
    end

    // Next state of pointers, counts and output register
    always_comb begin
        wptr_d = wptr_q;
        rptr_d = rptr_q;
        cnt_d  = cnt_q;
        wtot_d = wtot_q;
        rtot_d = rtot_q;
        dout_d = dout_q;
        outv_d = outv_q;
        if (!run) begin
            wptr_d = '0;
            rptr_d = '0;
            cnt_d  = '0;
            wtot_d = '0;
            rtot_d = '0;
            dout_d = '0;
            outv_d = 1'b0;
        end else begin
            if (wr_acc) begin
                wptr_d = step_ptr(wptr_q);
            end
            wtot_d = (wsum > WT_MAX) ? WT_MAX : wsum;
            if (rt_ok) begin
                if (fw) begin
                    dout_d = mem_rdata;
                    outv_d = 1'b1;
                    rptr_d = step_ptr('0);
                    cnt_d  = wsum - CW'(1);
                end else begin
                    rptr_d = '0;
                    cnt_d  = wsum;
                end
            end else if (fw) begin
                if (pop && rtot_q != 2'd2) begin
                    rtot_d = rtot_q + 2'd1;
                end
                if (load) begin
                    dout_d = mem_rdata;
                    outv_d = 1'b1;
                    rptr_d = step_ptr(rptr_q);
                end else if (pop) begin
                    outv_d = 1'b0;
                end
                cnt_d = cnt_q + {{(CW-1){1'b0}}, wr_acc} - {{(CW-1){1'b0}}, load};
            end else begin
                if (rd_acc) begin
                    dout_d = mem_rdata;
                    rptr_d = step_ptr(rptr_q);
                    if (rtot_q != 2'd2) begin
                        rtot_d = rtot_q + 2'd1;
                    end
                end
                cnt_d = cnt_q + {{(CW-1){1'b0}}, wr_acc} - {{(CW-1){1'b0}}, rd_acc};
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        wptr_q <= wptr_d;
        rptr_q <= rptr_d;
        cnt_q  <= cnt_d;
        wtot_q <= wtot_d;
        rtot_q <= rtot_d;
        dout_q <= dout_d;
        outv_q <= outv_d;
    end

    assign rd_data = dout_q;
endmodule

// File: rtl/pf_flags.sv
// Status flag register. Computes all five active-low flags from the
// next-state count, output-valid bit, mode and offsets, so each flag changes
// on the same edge as the state it reports. Resets reach it through those
// next-state inputs, which already hold the reset values.
module pf_flags
    import pf_pkg::*;
#(
    parameter int D  = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  rd_mode_e      mode_d,
    input  logic [CW-1:0] cnt_d,
    input  logic          outv_d,
    input  logic [CW-1:0] n_d,
    input  logic [CW-1:0] m_d,
    output logic          ef_or_n,
    output logic          ff_ir_n,
    output logic          pae_n,
    output logic          paf_n,
    output logic          hf_n
);
    localparam logic [CW:0]   CAP_S = (CW+1)'(D);
    localparam logic [CW:0]   CAP_F = (CW+1)'(D + 1);
    localparam logic [CW-1:0] DEP   = CW'(D);

    logic          fw;
    logic [CW:0]   lvl, cap, half;
    logic [CW+1:0] reach;

    // Level and thresholds for the coming state
    always_comb begin
        fw    = (mode_d == MODE_FWFT);
        lvl   = {1'b0, cnt_d} + {{CW{1'b0}}, outv_d};
        cap   = fw ? CAP_F : CAP_S;
        half  = cap >> 1;
        reach = {1'b0, lvl} + {2'b00, m_d};
    end

    // Register the flags
    always_ff @(posedge clk) begin
        ef_or_n <= fw ? !outv_d : (lvl != '0);
        ff_ir_n <= fw ? (cnt_d >= DEP) : (lvl != CAP_S);
        pae_n   <= (lvl > {1'b0, n_d});
        paf_n   <= (reach < {1'b0, cap});
        hf_n    <= (lvl <= half);
    end
endmodule

// File: rtl/pf_fifo.sv
// Programmable-flag FIFO top: configuration holder, controller, storage and
// flag register. Single clock; both resets synchronous and active low.
module pf_fifo
    import pf_pkg::*;
#(
    parameter int W     = 8,
    parameter int D     = 16,
    parameter int DEF_N = 2,
    parameter int DEF_M = 3,
    localparam int AW   = (D > 1) ? $clog2(D) : 1,
    localparam int CW   = $clog2(D + 3)
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          fwft_sel,
    input  logic          ofs_ld,
    input  logic [CW-1:0] ofs_empty,
    input  logic [CW-1:0] ofs_full,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic          rt_req,
    output logic [W-1:0]  rd_data,
    output logic          ef_or_n,
    output logic          ff_ir_n,
    output logic          pae_n,
    output logic          paf_n,
    output logic          hf_n
);
    rd_mode_e      mode_q, mode_d;
    logic [CW-1:0] ofs_n_q, ofs_n_d, ofs_m_q, ofs_m_d;
    logic [CW-1:0] cnt_q, cnt_d, level;
    logic          outv_q, outv_d, we, mode_fw;
    logic [AW-1:0] waddr, raddr;
    logic [W-1:0]  mem_rdata;

    pf_cfg #(.CW(CW), .DEF_N(DEF_N), .DEF_M(DEF_M)) u_cfg (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(fwft_sel),
        .ld(ofs_ld), .ld_n(ofs_empty), .ld_m(ofs_full),
        .mode_q(mode_q), .mode_d(mode_d), .n_q(ofs_n_q), .n_d(ofs_n_d),
        .m_q(ofs_m_q), .m_d(ofs_m_d)
    );

    pf_ctrl #(.W(W), .D(D), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode(mode_q),
        .wr_en(wr_en), .rd_en(rd_en), .rt_req(rt_req), .mem_rdata(mem_rdata),
        .we(we), .waddr(waddr), .raddr(raddr), .rd_data(rd_data),
        .cnt_q(cnt_q), .cnt_d(cnt_d), .outv_q(outv_q), .outv_d(outv_d)
    );

    pf_store #(.W(W), .D(D), .AW(AW)) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    pf_flags #(.D(D), .CW(CW)) u_flags (
        .clk(clk), .mode_d(mode_d), .cnt_d(cnt_d), .outv_d(outv_d),
        .n_d(ofs_n_d), .m_d(ofs_m_d),
        .ef_or_n(ef_or_n), .ff_ir_n(ff_ir_n), .pae_n(pae_n),
        .paf_n(paf_n), .hf_n(hf_n)
    );

    assign level   = cnt_q + {{(CW-1){1'b0}}, outv_q};
    assign mode_fw = (mode_q == MODE_FWFT);
endmodule

// File: rtl/pf_fifo_chk.sv
// Property checker for pf_fifo, bound to every instance of it.
// Relates the stored level (controller) to the flag register and the ports.
module pf_fifo_chk #(
    parameter int W  = 8,
    parameter int D  = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          mrst_n,
    input logic          prst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rt_req,
    input logic [W-1:0]  rd_data,
    input logic          ef_or_n,
    input logic          ff_ir_n,
    input logic          pae_n,
    input logic          paf_n,
    input logic          hf_n,
    input logic [CW-1:0] level,
    input logic          fwft,
    input logic [CW-1:0] ofs_n,
    input logic [CW-1:0] ofs_m
);
    int cap;
    assign cap = fwft ? D + 1 : D;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (int'(level) == cap && wr_en && !rd_en && !rt_req) |=> (int'(level) == cap));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (level == '0 && rd_en && !wr_en && !rt_req) |=> (level == '0 && $stable(rd_data)));

    // R3
    std_status_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        !fwft |-> ((ef_or_n == (level != '0)) && (ff_ir_n == (int'(level) != D))));

    // R6
    almost_empty_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        pae_n == (level > ofs_n));

    // R7
    almost_full_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        paf_n == ((int'(level) + int'(ofs_m)) < cap));

    // R8
    half_full_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        hf_n == (int'(level) <= cap / 2));

    // R12
    level_step_chk: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        !rt_req |=> ((int'(level) <= int'($past(level)) + 1) &&
                     (int'(level) + 1 >= int'($past(level)))));
endmodule

bind pf_fifo pf_fifo_chk #(.W(W), .D(D), .CW(CW)) u_chk (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .wr_en(wr_en), .rd_en(rd_en),
    .rt_req(rt_req), .rd_data(rd_data), .ef_or_n(ef_or_n), .ff_ir_n(ff_ir_n),
    .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n), .level(level), .fwft(mode_fw),
    .ofs_n(ofs_n_q), .ofs_m(ofs_m_q)
);

// File: tb/pf_fifo_test.sv
module pf_fifo_test;
    localparam int W     = 8;
    localparam int D     = 16;
    localparam int DEF_N = 2;
    localparam int DEF_M = 3;
    localparam int CW    = $clog2(D + 3);

    logic          clk = 1'b0;
    logic          mrst_n, prst_n, fwft_sel, ofs_ld, wr_en, rd_en, rt_req;
    logic [CW-1:0] ofs_empty, ofs_full;
    logic [W-1:0]  wr_data, rd_data;
    logic          ef_or_n, ff_ir_n, pae_n, paf_n, hf_n;

    int nchk = 0;
    int nfail = 0;

    // Reference model state
    logic [W-1:0] mq[$];
    logic [W-1:0] hist[$];
    logic [W-1:0] m_dout;
    bit           m_fw, m_ov, rt_hit;
    int           m_n, m_m, wtot, rtot;

    always #5 clk = ~clk;

    pf_fifo #(.W(W), .D(D), .DEF_N(DEF_N), .DEF_M(DEF_M)) uut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
        .ofs_ld(ofs_ld), .ofs_empty(ofs_empty), .ofs_full(ofs_full),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rt_req(rt_req),
        .rd_data(rd_data), .ef_or_n(ef_or_n), .ff_ir_n(ff_ir_n),
        .pae_n(pae_n), .paf_n(paf_n), .hf_n(hf_n)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp,
                       input string what);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int lvl_f();
        return mq.size() + int'(m_ov);
    endfunction

    function automatic int cap_f();
        return m_fw ? D + 1 : D;
    endfunction

    // One clock edge of the requirement model
    task automatic model(input bit w, input logic [W-1:0] wd, input bit r, input bit rt,
                         input bit mr, input bit pr, input bit ld, input int lnv, input int lmv);
        bit wacc, pop, load;
        int old;
        rt_hit = 0;
        if (!mr) begin
            m_fw = fwft_sel; m_n = DEF_N; m_m = DEF_M;
        end
        if (!mr || !pr) begin
            mq.delete(); hist.delete(); m_dout = '0; m_ov = 0; wtot = 0; rtot = 0;
            return;
        end
        if (ld) begin
            m_n = lnv; m_m = lmv;
        end
        old  = mq.size();
        wacc = w && old < D;
        if (rt && wtot >= 2 && rtot >= 2 && wtot + int'(wacc) <= D) begin
            rt_hit = 1;
            mq = hist;
            if (m_fw) begin
                m_dout = mq.pop_front();
                m_ov = 1;
            end
        end else if (m_fw) begin
            pop  = r && m_ov;
            load = old > 0 && (!m_ov || pop);
            if (pop) rtot++;
            if (load) begin
                m_dout = mq.pop_front(); m_ov = 1;
            end else if (pop) begin
                m_ov = 0;
            end
        end else if (r && old > 0) begin
            m_dout = mq.pop_front();
            rtot++;
        end
        if (wacc) begin
            mq.push_back(wd);
            if (hist.size() <= D) hist.push_back(wd);
            wtot++;
        end
    endtask

    // Drive one cycle, advance the model, compare all outputs after the edge
    task automatic cyc(input bit w, input logic [W-1:0] wd, input bit r, input bit rt,
                       input bit mr = 1, input bit pr = 1, input bit ld = 0,
                       input int lnv = 0, input int lmv = 0);
        string tm, td;
        int lv;
        wr_en = w; wr_data = wd; rd_en = r; rt_req = rt; mrst_n = mr; prst_n = pr;
        ofs_ld = ld; ofs_empty = CW'(lnv); ofs_full = CW'(lmv);
        @(posedge clk);
        model(w, wd, r, rt, mr, pr, ld, lnv, lmv);
        @(negedge clk);
        lv = lvl_f();
        tm = !mr ? "R1" : (!pr ? "R2" : (m_fw ? "R4" : "R3"));
        td = rt_hit ? "R10" : tm;
        chk(td, rd_data, m_dout, "rd_data");
        chk(tm, ef_or_n, m_fw ? !m_ov : (lv != 0), "ef_or_n");
        chk(tm, ff_ir_n, m_fw ? (mq.size() >= D) : (lv != D), "ff_ir_n");
        chk("R6", pae_n, lv > m_n, "pae_n");
        chk("R7", paf_n, (lv + m_m) < cap_f(), "paf_n");
        chk("R8", hf_n, lv <= cap_f() / 2, "hf_n");
    endtask

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        fwft_sel = 0; mrst_n = 0; prst_n = 1; ofs_ld = 0; ofs_empty = '0; ofs_full = '0;
        wr_en = 0; wr_data = '0; rd_en = 0; rt_req = 0;

        // ---- standard mode ----
        cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        chk("R1", ef_or_n, 0, "empty after reset"); chk("R1", ff_ir_n, 1, "full after reset");
        for (int i = 0; i < 4; i++) cyc(1, 8'hA0 + W'(i), 0, 0);
        cyc(0, 0, 1, 0); chk("R3", rd_data, 8'hA0, "first read");
        cyc(0, 0, 1, 0); chk("R3", rd_data, 8'hA1, "second read");
        cyc(0, 0, 1, 1); chk("R10", rd_data, 8'hA1, "read ignored during rewind");
        cyc(0, 0, 1, 0); chk("R10", rd_data, 8'hA0, "rewound read");
        // R11: only one read before request
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) cyc(1, 8'hB0 + W'(i), 0, 0);
        cyc(0, 0, 1, 0); cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 0); chk("R11", rd_data, 8'hB1, "rewind refused");
        // R5: overfill and overdrain
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < D + 3; i++) cyc(1, 8'hC0 + W'(i), 0, 0);
        chk("R5", ff_ir_n, 0, "full");
        for (int i = 0; i < D; i++) cyc(0, 0, 1, 0);
        chk("R5", rd_data, 8'hC0 + W'(D - 1), "last stored word");
        cyc(0, 0, 1, 0); chk("R5", rd_data, 8'hC0 + W'(D - 1), "read while empty");
        // R9 / R12: new offsets n=4 m=5
        cyc(0, 0, 0, 0, 1, 1, 1, 4, 5);
        for (int i = 0; i < D - 6; i++) cyc(1, W'(i), 0, 0);
        chk("R12", paf_n, 1, "below threshold");
        cyc(1, 8'h55, 0, 0);
        chk("R9", paf_n, 0, "threshold D-m"); chk("R12", pae_n, 1, "above n");
        // R2: partial reset keeps offsets
        cyc(0, 0, 0, 0, 1, 0, 1, 9, 9);
        for (int i = 0; i < D - 5; i++) cyc(1, W'(i), 0, 0);
        chk("R2", paf_n, 0, "offset kept");

        // ---- fall-through mode ----
        fwft_sel = 1;
        cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        chk("R1", ef_or_n, 1, "no output word"); chk("R1", ff_ir_n, 0, "ready");
        cyc(1, 8'hE0, 0, 0); chk("R4", ef_or_n, 1, "not yet on output");
        cyc(1, 8'hE1, 0, 0);
        chk("R4", ef_or_n, 0, "word fell through"); chk("R4", rd_data, 8'hE0, "first word");
        for (int i = 2; i < D + 1 - DEF_M - 1; i++) cyc(1, 8'hE0 + W'(i), 0, 0);
        chk("R1", paf_n, 1, "default m below");
        cyc(1, 8'hEE, 0, 0); chk("R1", paf_n, 0, "default m restored");
        for (int i = 0; i < DEF_M; i++) cyc(1, 8'hF8 + W'(i), 0, 0);
        chk("R4", ff_ir_n, 1, "holds D+1"); chk("R8", hf_n, 0, "over half");
        cyc(1, 8'h77, 0, 0);
        for (int i = 0; i < D + 2; i++) cyc(0, 0, 1, 0);
        chk("R4", ef_or_n, 1, "drained");
        cyc(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc(1, 8'hF0 + W'(i), 0, 0);
        cyc(0, 0, 0, 0); cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
        chk("R4", rd_data, 8'hF2, "after two reads");
        cyc(0, 0, 0, 1);
        chk("R10", rd_data, 8'hF0, "rewind at once"); chk("R10", ef_or_n, 0, "ready at once");

        // ---- constrained random ----
        for (int b = 0; b < 24; b++) begin
            int pw = $urandom_range(20, 85);
            int pr = $urandom_range(20, 85);
            for (int k = 0; k < 200; k++) begin
                bit w   = $urandom_range(0, 99) < pw;
                bit r   = $urandom_range(0, 99) < pr;
                bit rt  = $urandom_range(0, 40) == 0;
                bit mr  = $urandom_range(0, 499) != 0;
                bit prs = $urandom_range(0, 149) != 0;
                bit ld  = $urandom_range(0, 79) == 0;
                if (!mr) fwft_sel = 1'($urandom_range(0, 1));
                cyc(w, W'($urandom), r, rt, mr, prs, ld,
                    $urandom_range(0, D), $urandom_range(0, D));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule